// File: doc/BRIEF.md
# Bus Idle Request Arbiter

The arbiter sits inside a hot-plug slot controller and guards the moment a slot is joined to a shared parallel bus. When the slot sequencer raises its connect request, the arbiter asks the host bridge to quiesce the bus through an active-low idle-request output. It then waits for the bridge's active-low idle-grant. After the grant, the arbiter watches the bus framing and initiator-ready lines. On the first cycle where both lines read deasserted, it hands the sequencer a single-cycle connect-permission strobe.

A second, cascaded controller can place its own idle-request on the secondary-request input. The arbiter forwards that request upstream. While the upstream grant lasts and the secondary request stays asserted, it drives the active-low secondary-grant output back to the cascaded controller. When local and secondary requests arrive together, the local slot is served first. All asynchronous bus-side inputs pass through a parameterised synchronizer before use, and everything runs on the bus clock.

Top module: `bus_idle_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, `idle_req_n` and `sec_gnt_n` are high and `connect_ok` is low.
- R2: When the arbiter is idle and the synchronized grant is deasserted, a high `local_req` sampled at a rising edge drives `idle_req_n` low right after that edge.
- R3: `connect_ok` is high for exactly one cycle. It is issued only while serving a local request, and only after an edge where the synchronized grant was low and both `frame_n` and `irdy_n` were synchronized high. A low level on either bus line holds it off.
- R4: `frame_n`, `irdy_n`, `idle_gnt_n` and `sec_req_n` each pass through SYNC_STAGES flip-flops (default 2). A change driven before edge k first affects the outputs right after edge k+SYNC_STAGES.
- R5: `idle_req_n` returns high in the same cycle as the connect strobe. It is not driven low again until the synchronized grant has been seen deasserted (high).
- R6: A low `sec_req_n` with no local request pending (arbiter idle, grant deasserted) drives `idle_req_n` low.
- R7: `sec_gnt_n` is low only while `idle_req_n` is low and the synchronized secondary request and grant are both low. When `sec_req_n` is withdrawn, both `sec_gnt_n` and `idle_req_n` go high.
- R8: If `local_req` and a synchronized secondary request are both pending in the idle state, the local request is served first. `connect_ok` fires before any secondary grant.
- R9: With `sec_req_n` held high and no local request, `idle_req_n` stays high whatever the grant and bus lines do.
- R10: If `local_req` drops before the connect strobe, `idle_req_n` is released and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low bus reset |
| local_req | input | 1 | Connect request from the local slot sequencer (synchronous, level) |
| frame_n | input | 1 | Bus framing line, active low |
| irdy_n | input | 1 | Bus initiator-ready line, active low |
| idle_gnt_n | input | 1 | Idle grant from host bridge, active low |
| sec_req_n | input | 1 | Idle request from cascaded controller, active low |
| idle_req_n | output | 1 | Idle request to host bridge, active low |
| sec_gnt_n | output | 1 | Grant returned to cascaded controller, active low |
| connect_ok | output | 1 | One-cycle connect-permission strobe to the slot sequencer |

## Verification
Two events can land on the same edge: a local connect request and a secondary request. Both can be pending while the arbiter is idle. A directed phase raises both in one cycle, with a bench host that grants whenever asked. It is judged by requiring the connect strobe to come before the first secondary grant. The random phase mixes the two request sources, host grant lag and bus busy patterns against a cycle model built from the requirements. That model also covers the window in which the bus lines must be idle in the same cycle as the grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOCAL = 2'd1,
        ST_SEC   = 2'd2,
        ST_DRAIN = 2'd3
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
        logic       req;
        logic       sgnt;
        logic       conn;
    } arb_reg_t;

    localparam arb_reg_t ARB_RESET = '{state: ST_IDLE, req: 1'b0, sgnt: 1'b0, conn: 1'b0};

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic local_req,
    input  logic gnt,
    input  logic bus_idle,
    input  logic sreq,
    output logic req,
    output logic sgnt,
    output logic conn,
    output logic [1:0] state_o
);

    arb_reg_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.conn  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                // a stale grant must drop before a new request starts
                if (!gnt) begin
                    if (local_req) begin
                        r_d.state = ST_LOCAL;
                    end else if (sreq) begin
                        r_d.state = ST_SEC;
                    end
                end
            end
            ST_LOCAL: begin
                if (!local_req) begin
                    r_d.state = ST_DRAIN;
                end else if (gnt && bus_idle) begin
                    r_d.conn  = 1'b1;
                    r_d.state = ST_DRAIN;
                end
            end
            ST_SEC: begin
                if (!sreq) begin
                    r_d.state = ST_DRAIN;
                end
            end
            default: begin
                if (!gnt) begin
                    r_d.state = ST_IDLE;
                end
            end
        endcase
        r_d.req  = (r_d.state == ST_LOCAL) || (r_d.state == ST_SEC);
        r_d.sgnt = (r_d.state == ST_SEC) && gnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= ARB_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign req     = r_q.req;
    assign sgnt    = r_q.sgnt;
    assign conn    = r_q.conn;
    assign state_o = r_q.state;

endmodule

// File: rtl/bus_idle_arbiter.sv
module bus_idle_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic local_req,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic idle_gnt_n,
    input  logic sec_req_n,
    output logic idle_req_n,
    output logic sec_gnt_n,
    output logic connect_ok
);

    localparam int NUM_SYNC = 4;
    localparam int IX_FRAME = 0;
    localparam int IX_IRDY  = 1;
    localparam int IX_GNT   = 2;
    localparam int IX_SREQ  = 3;

    logic [NUM_SYNC-1:0] raw_in, synced;
    logic gnt_s, idle_s, sreq_s;
    logic req, sgnt, conn;
    logic [1:0] fsm_state;

    assign raw_in[IX_FRAME] = frame_n;
    assign raw_in[IX_IRDY]  = irdy_n;
    assign raw_in[IX_GNT]   = idle_gnt_n;
    assign raw_in[IX_SREQ]  = sec_req_n;

    arb_sync #(
        .WIDTH   (NUM_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NUM_SYNC{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (synced)
    );

    assign gnt_s  = !synced[IX_GNT];
    assign idle_s = synced[IX_FRAME] && synced[IX_IRDY];
    assign sreq_s = !synced[IX_SREQ];

    arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .local_req(local_req),
        .gnt      (gnt_s),
        .bus_idle (idle_s),
        .sreq     (sreq_s),
        .req      (req),
        .sgnt     (sgnt),
        .conn     (conn),
        .state_o  (fsm_state)
    );

    assign idle_req_n = !req;
    assign sec_gnt_n  = !sgnt;
    assign connect_ok = conn;

endmodule

// File: rtl/arb_checker.sv
module arb_checker (
    input logic clk,
    input logic rst_n,
    input logic local_req,
    input logic idle_req_n,
    input logic sec_gnt_n,
    input logic connect_ok,
    input logic gnt_s,
    input logic idle_s,
    input logic sreq_s
);

    AST_CONNECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        connect_ok |=> !connect_ok); // R3

    AST_CONNECT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        connect_ok |-> $past(gnt_s && idle_s && local_req)); // R3

    AST_RELEASE_ON_CONNECT: assert property (@(posedge clk) disable iff (!rst_n)
        connect_ok |-> idle_req_n); // R5

    AST_REARM_AFTER_GNT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_req_n) |-> $past(!gnt_s)); // R5

    AST_SGNT_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_gnt_n |-> !idle_req_n); // R7

    AST_SGNT_NEEDS_SREQ: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_gnt_n |-> $past(sreq_s && gnt_s)); // R7

    AST_NO_SGNT_WITH_CONNECT: assert property (@(posedge clk) disable iff (!rst_n)
        connect_ok |-> sec_gnt_n); // R8

endmodule

bind bus_idle_arbiter arb_checker u_arb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .local_req (local_req),
    .idle_req_n(idle_req_n),
    .sec_gnt_n (sec_gnt_n),
    .connect_ok(connect_ok),
    .gnt_s     (gnt_s),
    .idle_s    (idle_s),
    .sreq_s    (sreq_s)
);

// File: tb/tb_bus_idle_arbiter.sv
`timescale 1ns/1ps
module tb_bus_idle_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic local_req = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, idle_gnt_n = 1'b1, sec_req_n = 1'b1;
    logic idle_req_n, sec_gnt_n, connect_ok;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // model state: 0 idle, 1 local, 2 secondary, 3 drain
    int  m_st = 0;
    bit  m_req = 0, m_sgnt = 0, m_conn = 0;
    bit  s1_f = 1, s1_i = 1, s1_g = 1, s1_s = 1;
    bit  s2_f = 1, s2_i = 1, s2_g = 1, s2_s = 1;
    int  cyc = 0;

    always #2.5 clk = ~clk;

    bus_idle_arbiter dut (
        .clk(clk), .rst_n(rst_n), .local_req(local_req),
        .frame_n(frame_n), .irdy_n(irdy_n), .idle_gnt_n(idle_gnt_n),
        .sec_req_n(sec_req_n), .idle_req_n(idle_req_n),
        .sec_gnt_n(sec_gnt_n), .connect_ok(connect_ok)
    );

    function automatic int next_state(int st, bit lr, bit g, bit idl, bit sr);
        case (st)
            0: return (!g && lr) ? 1 : ((!g && sr) ? 2 : 0);
            1: return (!lr || (g && idl)) ? 3 : 1;
            2: return sr ? 2 : 3;
            default: return g ? 3 : 0;
        endcase
    endfunction

    task automatic check_bit(string name, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", tag, name, act, exp, cyc);
        end
    endtask

    // one cycle: compare outputs at the falling edge, then apply new inputs
    task automatic step(bit lr, bit f, bit i, bit gn, bit sn);
        bit g, idl, sr;
        int nst;
        @(negedge clk);
        cyc++;
        check_bit("idle_req_n", idle_req_n, !m_req);
        check_bit("sec_gnt_n", sec_gnt_n, !m_sgnt);
        check_bit("connect_ok", connect_ok, m_conn);
        local_req = lr; frame_n = f; irdy_n = i; idle_gnt_n = gn; sec_req_n = sn;
        g = !s2_g; idl = s2_f && s2_i; sr = !s2_s;
        nst = next_state(m_st, lr, g, idl, sr);
        m_conn = (m_st == 1) && lr && g && idl;
        m_req  = (nst == 1) || (nst == 2);
        m_sgnt = (nst == 2) && g;
        m_st   = nst;
        s2_f = s1_f; s2_i = s1_i; s2_g = s1_g; s2_s = s1_s;
        s1_f = f; s1_i = i; s1_g = gn; s1_s = sn;
    endtask

    // bench host grants when asked; sequencer drops after strobe;
    // cascade drops after holding its grant a few cycles
    int first_conn, first_sgnt;
    task automatic auto_run(int n, bit lr0, bit sn0);
        bit lr = lr0, sn = sn0;
        int held = 0;
        first_conn = -1; first_sgnt = -1;
        for (int k = 0; k < n; k++) begin
            if (connect_ok && first_conn < 0) first_conn = k;
            if (!sec_gnt_n && first_sgnt < 0) first_sgnt = k;
            if (connect_ok) lr = 0;
            if (!sec_gnt_n) held++;
            if (held >= 3) sn = 1;
            step(lr, 1, 1, idle_req_n, sn);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        tag = "R1";
        check_bit("idle_req_n", idle_req_n, 1'b1);
        check_bit("sec_gnt_n", sec_gnt_n, 1'b1);
        check_bit("connect_ok", connect_ok, 1'b0);
        rst_n = 1'b1;
        repeat (3) step(0, 1, 1, 1, 1);

        // no cascade: random bus and grant noise, no request may appear
        tag = "R9";
        for (int k = 0; k < 40; k++) begin
            step(0, 1'($urandom), 1'($urandom), 1'($urandom), 1);
            checks++;
            if (!idle_req_n) begin
                failures++;
                $display("FAIL R9 idle_req_n actual=0 expected=1");
            end
        end
        repeat (4) step(0, 1, 1, 1, 1);

        // local request, grant withheld
        tag = "R2";
        repeat (5) step(1, 1, 1, 1, 1);
        // grant given but bus busy
        tag = "R3";
        repeat (6) step(1, 0, 1, 0, 1);
        repeat (3) step(1, 1, 0, 0, 1);
        // bus goes idle: strobe after the synchronizer latency
        tag = "R4";
        repeat (4) step(1, 1, 1, 0, 1);
        tag = "R5";
        repeat (4) step(0, 1, 1, 0, 1);
        repeat (2) step(1, 1, 1, 0, 1);
        repeat (6) step(1, 1, 1, 1, 1);
        repeat (6) step(0, 1, 1, 1, 1);

        // withdrawn request
        tag = "R10";
        repeat (3) step(1, 1, 1, 1, 1);
        repeat (6) step(0, 1, 1, 1, 1);
        repeat (4) step(0, 1, 1, 0, 1);
        repeat (4) step(0, 1, 1, 1, 1);

        // secondary alone
        tag = "R6";
        repeat (5) step(0, 1, 1, 1, 0);
        tag = "R7";
        repeat (5) step(0, 1, 1, 0, 0);
        repeat (5) step(0, 1, 1, 0, 1);
        repeat (5) step(0, 1, 1, 1, 1);

        // simultaneous requests
        tag = "R8";
        auto_run(40, 1, 0);
        checks++;
        if (first_conn < 0 || first_sgnt < 0 || first_conn >= first_sgnt) begin
            failures++;
            $display("FAIL R8 order actual conn=%0d sgnt=%0d expected conn<sgnt", first_conn, first_sgnt);
        end
        repeat (6) step(0, 1, 1, 1, 1);

        // random mix
        tag = "R2/R3/R5/R7";
        begin
            bit lr = 0, sn = 1, gn = 1;
            for (int k = 0; k < 3000; k++) begin
                if (connect_ok || ($urandom % 40 == 0)) lr = 0;
                else if ($urandom % 8 == 0) lr = 1;
                if ($urandom % 12 == 0) sn = !sn;
                if ($urandom % 3 != 0) gn = idle_req_n;
                else if ($urandom % 10 == 0) gn = !gn;
                step(lr, ($urandom % 4 != 0), ($urandom % 4 != 0), gn, sn);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule